// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst. A surrounding memory controller hands it a base address. On each later cycle it either loads a new base or steps to the next beat. Only the two lowest address bits change over a burst. Every bit above them holds the loaded base value until the next load.

The order of the low bits is picked by a select input. With the select high, the low bits are the base low bits XORed with the beat number (interleaved order). With the select low, they are the base low bits plus the beat number, modulo four (linear order). The select acts combinationally on the output, so it may be tied off or changed between bursts.

A clock enable freezes the whole sequencer. The current beat number is an output, so the controller can see when the burst wraps: stepping past beat 3 returns to beat 0 of the same burst, which is the base address again.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset (active low) is held and in the first cycle after it, `curAddr` is 0 and `beatIdx` is 0.
- R2: At a clock edge with `clkEn`=1 and `advLd`=0, `baseAddr` is stored. From the next cycle `beatIdx` is 0 and `curAddr` equals the stored base.
- R3: At a clock edge with `clkEn`=1 and `advLd`=1, `beatIdx` advances by one, modulo 4.
- R4: With `orderSel`=1, `curAddr[1:0]` equals the stored base bits [1:0] XOR `beatIdx`.
- R5: With `orderSel`=0, `curAddr[1:0]` equals (stored base bits [1:0] + `beatIdx`) modulo 4.
- R6: `curAddr[ADDR_W-1:2]` always equals bits [ADDR_W-1:2] of the most recently stored base.
- R7: At a clock edge with `clkEn`=0, the stored base and `beatIdx` keep their values whatever `advLd` and `baseAddr` carry.
- R8: An advance from beat 3 gives beat 0, and `curAddr` returns to the stored base address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| clkEn | input | 1 | Clock enable; 0 holds all state |
| advLd | input | 1 | 0 loads a new base, 1 steps to the next beat |
| orderSel | input | 1 | 1 selects interleaved (XOR) order, 0 selects linear (add) order |
| baseAddr | input | ADDR_W | Base address stored on a load |
| curAddr | output | ADDR_W | Address of the current beat |
| beatIdx | output | 2 | Number of the current beat, 0 to 3 |

## Verification
The bench starts bursts from each of the four low-bit base values in both orders. The linear and interleaved orders give the same addresses for a base of 0. Only the nonzero bases can show a design that adds where it should XOR, or swaps the two orders. Stalls are placed mid-burst while `advLd` and `baseAddr` toggle. A design that lets either of them through the enable would skip a beat or pick up a new base. Each burst is also advanced past its fourth beat. The upper address bits are checked on every beat, so a carry out of the low bits into bit 2 would show up as a wrong upper address. A counter that failed to wrap would show up the same way.

// File: rtl/burst_addr_seq_pkg.sv
package burst_addr_seq_pkg;
  localparam int BEAT_W = 2;

  typedef struct packed {
    logic loadBase;
    logic stepBeat;
  } seq_strobe_t;
endpackage

// File: rtl/burst_addr_seq_ctrl.sv
module burst_addr_seq_ctrl
  import burst_addr_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advLd,
  output seq_strobe_t       strobes,
  output logic [BEAT_W-1:0] beatCnt
);
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beatNext;

  always_comb begin
    strobes.loadBase = clkEn & ~advLd;
    strobes.stepBeat = clkEn & advLd;
  end

  always_comb begin
    beatNext = beatCnt;
    if (strobes.loadBase)      beatNext = '0;
    else if (strobes.stepBeat) beatNext = beatCnt + BEAT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) beatCnt <= '0;
    else       beatCnt <= beatNext;
  end
endmodule

// File: rtl/burst_addr_seq_dp.sv
module burst_addr_seq_dp
  import burst_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobes,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [BEAT_W-1:0] beatCnt,
  output logic [ADDR_W-1:0] curAddr
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] baseReg;
  logic [BEAT_W-1:0] baseLow;
  logic [BEAT_W-1:0] xorLow;
  logic [BEAT_W-1:0] addLow;
  logic [BEAT_W-1:0] seqLow;

  always_ff @(posedge clk) begin
    if (!rstN)                 baseReg <= '0;
    else if (strobes.loadBase) baseReg <= baseAddr;
  end

  assign baseLow = baseReg[BEAT_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < BEAT_W; gi++) begin : g_xor
      assign xorLow[gi] = baseLow[gi] ^ beatCnt[gi];
    end
  endgenerate

  assign addLow = baseLow + beatCnt;
  assign seqLow = orderSel ? xorLow : addLow;

  generate
    if (HI_W > 0) begin : g_hi
      assign curAddr = {baseReg[ADDR_W-1:BEAT_W], seqLow};
    end else begin : g_nohi
      assign curAddr = seqLow;
    end
  endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_addr_seq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advLd,
  input  logic              orderSel,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic [ADDR_W-1:0] curAddr,
  output logic [1:0]        beatIdx
);
  seq_strobe_t       strobes;
  logic [BEAT_W-1:0] beatCnt;

  burst_addr_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLd(advLd),
    .strobes(strobes), .beatCnt(beatCnt)
  );

  burst_addr_seq_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .orderSel(orderSel),
    .baseAddr(baseAddr), .beatCnt(beatCnt), .curAddr(curAddr)
  );

  assign beatIdx = beatCnt;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              advLd,
  input logic              orderSel,
  input logic [ADDR_W-1:0] baseAddr,
  input logic [ADDR_W-1:0] curAddr,
  input logic [1:0]        beatIdx
);
  logic [ADDR_W-1:0] shadowBase;

  always_ff @(posedge clk) begin
    if (!rstN)                shadowBase <= '0;
    else if (clkEn && !advLd) shadowBase <= baseAddr;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (beatIdx == 2'd0 && curAddr == '0));

  assert_load_base_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLd) |=> (beatIdx == 2'd0 && curAddr == $past(baseAddr)));

  assert_step_beat_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLd) |=> (beatIdx == 2'($past(beatIdx) + 2'd1)));

  assert_xor_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    orderSel |-> (curAddr[1:0] == (shadowBase[1:0] ^ beatIdx)));

  assert_add_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    !orderSel |-> (curAddr[1:0] == 2'(shadowBase[1:0] + beatIdx)));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    curAddr[ADDR_W-1:2] == shadowBase[ADDR_W-1:2]);

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(beatIdx) && $stable(curAddr[ADDR_W-1:2])));

  assert_wrap_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLd && beatIdx == 2'd3) |=> (beatIdx == 2'd0 && curAddr == shadowBase));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLd(advLd), .orderSel(orderSel),
  .baseAddr(baseAddr), .curAddr(curAddr), .beatIdx(beatIdx)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 20;
  localparam int NVEC = 16;
  // entry: [6]=clkEn [5]=advLd [4]=orderSel [3:2]=upper seed [1:0]=base low bits
  localparam logic [6:0] VECS [NVEC] = '{
    7'b1_0_1_01_10, 7'b1_1_1_00_00, 7'b1_1_1_00_00, 7'b0_1_1_11_01,
    7'b1_1_1_00_00, 7'b1_1_1_00_00, 7'b1_0_0_10_11, 7'b1_1_0_00_00,
    7'b0_0_0_01_00, 7'b1_1_0_00_00, 7'b1_1_0_00_00, 7'b1_1_0_00_00,
    7'b0_0_1_11_10, 7'b1_1_1_00_00, 7'b1_0_1_11_01, 7'b1_1_1_00_00
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b0;
  logic advLd = 1'b0;
  logic orderSel = 1'b1;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [ADDR_W-1:0] curAddr;
  logic [1:0] beatIdx;

  int checks = 0;
  int errors = 0;
  logic [ADDR_W-1:0] refBase = '0;
  logic [1:0] refBeat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLd(advLd), .orderSel(orderSel),
    .baseAddr(baseAddr), .curAddr(curAddr), .beatIdx(beatIdx)
  );

  function automatic logic [ADDR_W-1:0] mkBase(input logic [1:0] seed, input logic [1:0] low);
    logic [ADDR_W-3:0] hi;
    hi = (ADDR_W-2)'((32'(seed) + 32'd1) * 32'h0002_B6D5);
    return {hi, low};
  endfunction

  function automatic logic [1:0] expLow(input logic [1:0] b, input logic [1:0] n, input logic sel);
    return sel ? (b ^ n) : 2'(b + n);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic adv, input logic sel, input logic [ADDR_W-1:0] b);
    bit wrapped;
    @(negedge clk);
    clkEn = en; advLd = adv; orderSel = sel; baseAddr = b;
    wrapped = 1'b0;
    if (en && !adv) begin refBase = b; refBeat = 2'd0; end
    else if (en) begin wrapped = (refBeat == 2'd3); refBeat = refBeat + 2'd1; end
    @(posedge clk); #1;
    check(!en ? "R7 beat hold" : (adv ? "R3 beat step" : "R2 beat load"), 32'(beatIdx), 32'(refBeat));
    check("R6 upper bits", 32'(curAddr[ADDR_W-1:2]), 32'(refBase[ADDR_W-1:2]));
    check(sel ? "R4 xor order" : "R5 add order", 32'(curAddr[1:0]),
          32'(expLow(refBase[1:0], refBeat, sel)));
    if (wrapped) check("R8 wrap to base", 32'(curAddr), 32'(refBase));
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; clkEn = 1'b1; advLd = 1'b1;
    @(posedge clk); #1;
    check("R1 reset beat", 32'(beatIdx), 32'd0);
    check("R1 reset addr", 32'(curAddr), 32'd0);
    @(negedge clk); rstN = 1'b1; clkEn = 1'b0;
    refBase = '0; refBeat = 2'd0;
    #1;
    check("R1 after reset addr", 32'(curAddr), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i][6], VECS[i][5], VECS[i][4], mkBase(VECS[i][3:2], VECS[i][1:0]));
    end
    for (int s = 0; s < 2; s++) begin
      for (int lo = 0; lo < 4; lo++) begin
        step(1'b1, 1'b0, s[0], mkBase(2'(lo), 2'(lo)));
        step(1'b1, 1'b1, s[0], '0);
        step(1'b1, 1'b1, s[0], '0);
        step(1'b0, 1'b0, s[0], ~mkBase(2'(lo), 2'(lo)));
        step(1'b0, 1'b1, s[0], '1);
        step(1'b1, 1'b1, s[0], '0);
        step(1'b1, 1'b1, s[0], '0);
        step(1'b1, 1'b1, s[0], '0);
      end
    end
    step(1'b1, 1'b0, 1'b0, {{(ADDR_W-2){1'b1}}, 2'b11});
    for (int k = 0; k < 5; k++) step(1'b1, 1'b1, 1'b0, '0);
    doReset();
    step(1'b1, 1'b1, 1'b1, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule